// File: doc/BRIEF.md
# Serial Flash Register Write Guard

This block sits on the pin side of a serial NOR flash model. It owns two 8-bit registers, a status byte and a configuration byte, and updates them from a register-write command that a host shifts in over an SPI slave link. It also decides whether those registers are locked by hardware. That decision uses a lock-enable bit in the status byte, an active-low write-protect pin and a quad-mode bit in the configuration byte. The SPI pins and the protect pin are asynchronous to the block clock. They pass through a synchronizer, and the block detects SCK edges by oversampling. SCK must therefore stay below roughly a quarter of the clock rate.

A host first sends the write-enable opcode and then the register-write opcode followed by two data bytes. The lock engages when the lock-enable bit is 1 and the pin is low, whichever of the two happens first. It releases only when the pin returns high. All pins are plain level signals with no valid/ready handshake. The host paces every bit through SCK and closes a command by raising CS#. No back-pressure path exists, so a command that arrives is always either taken or dropped.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `status_o` and `config_o` are 00h and `hw_protect_o` is 0.
- R2: A register-write frame is opcode 01h, then a status byte, then a configuration byte, each sent MSB first and sampled on SCK rising edges. An accepted frame loads status bits 7..2 and all eight configuration bits. Status bit 1 always reads as the write-enable latch, and status bit 0 always reads 0.
- R3: Opcode 06h with CS# rising after exactly 8 SCK rising edges sets the write-enable latch, which is visible as `status_o[1]`.
- R4: A register-write frame that arrives while the latch is clear changes neither register.
- R5: A register-write frame of exactly 24 bits clears the latch, whether or not the write was taken.
- R6: A frame with any other bit count, or with an opcode other than 06h or 01h, changes neither register nor the latch.
- R7: `hw_protect_o` is 1 exactly when status bit 7 is 1, the protect pin is low and configuration bit 1 (quad) is 0. It does not matter which of the bit and the pin arrived first.
- R8: While `hw_protect_o` is 1, a register-write frame leaves both registers unchanged, including an attempt to clear status bit 7.
- R9: Once protection is active, it ends only when the protect pin goes high.
- R10: When configuration bit 1 is 1, protection stays off for every value of status bit 7 and the pin, and register writes proceed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select; a rising edge ends a command |
| si_i | input | 1 | SPI serial data in |
| wp_n_i | input | 1 | Active-low hardware write-protect pin |
| status_o | output | 8 | Status byte: bit 7 lock enable, bit 1 write-enable latch, bit 0 zero |
| config_o | output | 8 | Configuration byte; bit 1 selects quad mode |
| hw_protect_o | output | 1 | High while the registers are hardware-locked |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, 8-bit registers, quad flag at bit 1 and lock-enable at bit 7. With these values a full command is short enough to sweep 64 status/configuration byte pairs through accepted writes. The bench also walks all eight combinations of lock bit, pin level and quad bit. Frames cut at 9, 23 and 32 bits and a foreign opcode exercise the bit-count and opcode filter. Dedicated sequences check that the lock engages in pin-first order and that quad mode cancels it.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int OP_W        = 8;
  localparam logic [OP_W-1:0] OP_WREN = 8'h06;
  localparam logic [OP_W-1:0] OP_WRR  = 8'h01;
  localparam int REG_W       = 8;
  localparam int QUAD_BIT    = 1;
  localparam int LOCK_BIT    = REG_W - 1;
  localparam int WEL_BIT     = 1;
  localparam logic [REG_W-1:0] SR_WRITE_MASK = 8'hFC;
endpackage

// File: rtl/flash_wp_spi_rx.sv
module flash_wp_spi_rx
  import flash_wp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              wp_n_i,
  output logic              wren_o,
  output logic              wrr_o,
  output logic [DATA_W-1:0] sr_data_o,
  output logic [DATA_W-1:0] cr_data_o,
  output logic              wp_n_o
);
  localparam int FRAME_BITS = OP_W + 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [3:0] PIN_IDLE = 4'b0101; // {sck, cs_n, si, wp_n}

  logic [3:0] stg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= PIN_IDLE;
    else        stg[0] <= {sck_i, cs_n_i, si_i, wp_n_i};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= PIN_IDLE;
      else        stg[g] <= stg[g-1];
    end
  end

  logic s_sck, s_cs, s_si;
  assign {s_sck, s_cs, s_si, wp_n_o} = stg[SYNC_STAGES-1];

  logic sck_d, cs_d;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic sck_rise, cs_rise;

  assign sck_rise = s_sck & ~sck_d;
  assign cs_rise  = s_cs & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
      cnt   <= '0;
      shreg <= '0;
    end else begin
      sck_d <= s_sck;
      cs_d  <= s_cs;
      if (s_cs) begin
        cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], s_si};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_o    <= 1'b0;
      wrr_o     <= 1'b0;
      sr_data_o <= '0;
      cr_data_o <= '0;
    end else begin
      wren_o    <= cs_rise && (cnt == CNT_OP) && (shreg[OP_W-1:0] == OP_WREN);
      wrr_o     <= cs_rise && (cnt == CNT_FULL) && (shreg[FRAME_BITS-1 -: OP_W] == OP_WRR);
      sr_data_o <= shreg[2*DATA_W-1 -: DATA_W];
      cr_data_o <= shreg[DATA_W-1:0];
    end
  end

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_o, wrr_o})); // R6

  AST_COMMAND_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wrr_o |=> !wrr_o); // R5
endmodule

// File: rtl/flash_wp_regs.sv
module flash_wp_regs
  import flash_wp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wren_i,
  input  logic             wrr_i,
  input  logic [REG_W-1:0] sr_data_i,
  input  logic [REG_W-1:0] cr_data_i,
  input  logic             wp_n_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] config_o,
  output logic             hw_protect_o
);
  logic [REG_W-1:0] sr_q, cr_q;
  logic             wel;
  logic             locked;
  logic             take_write;

  assign locked       = sr_q[LOCK_BIT] & ~wp_n_i & ~cr_q[QUAD_BIT];
  assign take_write   = wrr_i & wel & ~locked;
  assign hw_protect_o = locked;
  assign status_o     = sr_q | (REG_W'(wel) << WEL_BIT);
  assign config_o     = cr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      cr_q <= '0;
      wel  <= 1'b0;
    end else begin
      if (take_write) begin
        sr_q <= sr_data_i & SR_WRITE_MASK;
        cr_q <= cr_data_i;
      end
      if (wrr_i)       wel <= 1'b0;
      else if (wren_i) wel <= 1'b1;
    end
  end

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(sr_q) && $stable(cr_q)); // R8

  AST_NO_WEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel && !wren_i) |=> $stable(sr_q) && $stable(cr_q)); // R4

  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wrr_i |=> !status_o[WEL_BIT]); // R5

  AST_WEL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_i && !wrr_i) |=> status_o[WEL_BIT]); // R3

  AST_UNLOCK_BY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_protect_o) |-> wp_n_i); // R9

  AST_QUAD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_q[QUAD_BIT]) |-> !$past(locked)); // R10
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             si_i,
  input  logic             wp_n_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] config_o,
  output logic             hw_protect_o
);
  logic             wren, wrr, wp_n_s;
  logic [REG_W-1:0] sr_data, cr_data;

  flash_wp_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(REG_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_i     (sck_i),
    .cs_n_i    (cs_n_i),
    .si_i      (si_i),
    .wp_n_i    (wp_n_i),
    .wren_o    (wren),
    .wrr_o     (wrr),
    .sr_data_o (sr_data),
    .cr_data_o (cr_data),
    .wp_n_o    (wp_n_s)
  );

  flash_wp_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wren_i       (wren),
    .wrr_i        (wrr),
    .sr_data_i    (sr_data),
    .cr_data_i    (cr_data),
    .wp_n_i       (wp_n_s),
    .status_o     (status_o),
    .config_o     (config_o),
    .hw_protect_o (hw_protect_o)
  );
endmodule

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic [7:0] status, cfg;
  logic prot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .wp_n_i(wp_n), .status_o(status), .config_o(cfg), .hw_protect_o(prot)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = bits[31-i];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wren();
    send({8'h06, 24'h0}, 8);
  endtask

  task automatic wrr(input logic [7:0] s, input logic [7:0] c);
    send({8'h01, s, c, 8'h0}, 24);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); wp_n = v;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 config", cfg, 8'h00);
    chk("R1 protect", {7'd0, prot}, 8'h00);

    wrr(8'hFC, 8'hFF);
    chk("R4 status", status, 8'h00);
    chk("R4 config", cfg, 8'h00);

    send({8'h06, 24'h0}, 9);
    chk("R6 wren 9 bits", status, 8'h00);
    send({8'h05, 24'h0}, 8);
    chk("R6 foreign opcode", status, 8'h00);
    wren();
    chk("R3 wel set", status, 8'h02);
    send({8'h01, 8'hFC, 8'hFF, 8'h0}, 23);
    chk("R6 wrr 23 bits status", status, 8'h02);
    chk("R6 wrr 23 bits config", cfg, 8'h00);
    send({8'h01, 8'hFC, 8'hFF, 8'h5A}, 32);
    chk("R6 wrr 32 bits status", status, 8'h02);
    chk("R6 wrr 32 bits config", cfg, 8'h00);

    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = 8'(i * 4 + (i % 4));
      wren();
      wrr(v, ~v);
      chk("R2 R5 status", status, v & 8'hFC);
      chk("R2 config", cfg, ~v);
    end

    for (int c = 0; c < 8; c++) begin
      logic lock, pin_low, quad, exp_p;
      logic [7:0] s0, c0;
      lock = c[2]; pin_low = c[1]; quad = c[0];
      set_pin(1'b1);
      s0 = lock ? 8'h9C : 8'h1C;
      c0 = quad ? 8'h02 : 8'h00;
      wren(); wrr(s0, c0);
      set_pin(~pin_low);
      exp_p = lock & pin_low & ~quad;
      chk(quad ? "R10 protect" : "R7 protect", {7'd0, prot}, {7'd0, exp_p});
      wren(); wrr(8'h00, 8'h00);
      chk("R8 status", status, exp_p ? s0 : 8'h00);
      chk("R8 config", cfg, exp_p ? c0 : 8'h00);
      set_pin(1'b1);
      chk("R9 released", {7'd0, prot}, 8'h00);
    end

    set_pin(1'b0);
    wren(); wrr(8'h80, 8'h00);
    chk("R7 pin first", {7'd0, prot}, 8'h01);
    wren(); wrr(8'h00, 8'h02);
    chk("R8 clear lock blocked", status, 8'h80);
    chk("R8 quad blocked", cfg, 8'h00);
    chk("R9 still locked", {7'd0, prot}, 8'h01);
    set_pin(1'b1);
    chk("R9 pin high", {7'd0, prot}, 8'h00);
    wren(); wrr(8'h80, 8'h02);
    set_pin(1'b0);
    chk("R10 quad overrides", {7'd0, prot}, 8'h00);
    wren(); wrr(8'h00, 8'h00);
    chk("R10 write allowed", status, 8'h00);
    chk("R10 config written", cfg, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule